// File: doc/BRIEF.md
# Raw Video Frame-Valid Qualifier and Line Gate

This block sits on one raw parallel video input. Each clock it receives a frame strobe (vertical sync), a line strobe (horizontal sync) and a pixel word. It first brings both strobes to active-high form, using one static inversion bit per strobe. It then counts how many clocks the frame strobe has been active. The count is taken in the block's own clock, not in pixels. The first line of a frame is trusted only if the frame strobe was active for at least a programmable number of clocks before that line began.

If the first line starts too early, it is a setup violation, and a static mode bit selects the outcome. In drop mode the whole first line is removed. In forward mode the line is kept, but its pixels are held back until the count reaches the minimum, so the line appears with its leading pixels missing. Each violating first line raises a one-cycle error pulse. All later lines in the same frame pass untouched.

All outputs leave the block through one register stage.

Top module: `fv_line_gate`

## Requirements
- R1: When `cfg_fv_inv` is 1 the frame strobe is treated as active-low; when 0, as active-high.
- R2: When `cfg_lv_inv` is 1 the line strobe is treated as active-low; when 0, as active-high.
- R3: `out_fv` equals the normalised input frame strobe of the previous clock. `out_lv`, `out_data` and `out_err` come from the same register stage.
- R4: Frame-active clocks are counted from 0 at the first active cycle. Suppose the first line of a frame begins when k frame-active clocks have already passed. If k is at least `cfg_min_setup`, that line is forwarded in full.
- R5: With `cfg_fwd_short` = 0, a first line with k below `cfg_min_setup` is removed entirely: `out_lv` stays 0 for its whole length.
- R6: With `cfg_fwd_short` = 1, a violating first line is forwarded from the cycle at which the frame-active count equals `cfg_min_setup` to the line's end. Before that cycle `out_lv` is 0.
- R7: `out_err` is high for exactly one cycle for each violating first line, in both modes. It is aligned with the line's first pixel.
- R8: Every line after the first within one frame-active period passes unchanged.
- R9: The frame-active count restarts when the frame strobe deasserts, so every frame's first line is checked afresh.
- R10: `out_data` is zero whenever `out_lv` is 0; otherwise it carries the input pixel word.
- R11: A synchronous reset drives all outputs to 0 and clears the count and the first-line tracking.
- R12: The 16-bit count saturates at 65535 and does not wrap, so a setup of 65535 is met after a long enough frame lead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_fv_inv | input | 1 | Frame strobe is active-low when set |
| cfg_lv_inv | input | 1 | Line strobe is active-low when set |
| cfg_fwd_short | input | 1 | Forward a violating first line with its leading pixels removed, instead of dropping it |
| cfg_min_setup | input | 16 | Minimum frame-active clocks before the first line |
| in_fv | input | 1 | Raw frame strobe |
| in_lv | input | 1 | Raw line strobe |
| in_data | input | 12 | Raw pixel word |
| out_fv | output | 1 | Qualified frame strobe, active high |
| out_lv | output | 1 | Qualified line strobe, active high |
| out_data | output | 12 | Qualified pixel word |
| out_err | output | 1 | One-cycle pulse on a violating first line |

## Verification
Every result is due exactly one clock after the input cycle that causes it. The frame strobe, the gated line strobe, the pixel word and the error pulse all come from a single register stage. The bench changes inputs on the falling edge and compares all four outputs on the next falling edge. That comparison therefore sees the registered response to the input set just driven, with no extra delay to track. Expected values come from the frame's position arithmetic: the line start offset k, the setup minimum and the mode.

// File: rtl/fvlg_pkg.sv
package fvlg_pkg;

    typedef enum logic [1:0] {
        GATE_WAIT  = 2'd0,
        GATE_DROP  = 2'd1,
        GATE_TRUNC = 2'd2,
        GATE_PASS  = 2'd3
    } gate_mode_e;

    typedef struct packed {
        gate_mode_e mode;
        logic       lv_prev;
    } gate_track_t;

endpackage

// File: rtl/fvlg_polarity.sv
module fvlg_polarity (
    input  logic inv_fv,
    input  logic inv_lv,
    input  logic raw_fv,
    input  logic raw_lv,
    output logic norm_fv,
    output logic norm_lv
);
    always_comb begin
        norm_fv = raw_fv ^ inv_fv;
        norm_lv = raw_lv ^ inv_lv;
    end
endmodule

// File: rtl/fvlg_setup_counter.sv
module fvlg_setup_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fv,
    input  logic [CNT_W-1:0] min_setup,
    output logic [CNT_W-1:0] cnt_o,
    output logic             met_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!fv)
            cnt_d = '0;
        else if (cnt_q == CNT_MAX)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
        met_o = (cnt_q >= min_setup);
        cnt_o = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end
endmodule

// File: rtl/fvlg_line_gate.sv
module fvlg_line_gate
    import fvlg_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fv,
    input  logic              lv,
    input  logic [DATA_W-1:0] data,
    input  logic              met,
    input  logic              fwd_short,
    output logic              o_fv,
    output logic              o_lv,
    output logic [DATA_W-1:0] o_data,
    output logic              o_err
);
    typedef struct packed {
        logic              fv;
        logic              lv;
        logic [DATA_W-1:0] data;
        logic              err;
    } out_reg_t;

    gate_track_t trk_d, trk_q;
    out_reg_t    out_d, out_q;
    logic        line_start;
    logic        pass;
    logic        err;

    always_comb begin
        trk_d      = trk_q;
        pass       = 1'b0;
        err        = 1'b0;
        line_start = fv && lv && !trk_q.lv_prev;

        case (trk_q.mode)
            GATE_WAIT: begin
                if (line_start) begin
                    if (met) begin
                        pass       = 1'b1;
                        trk_d.mode = GATE_PASS;
                    end else begin
                        err        = 1'b1;
                        trk_d.mode = fwd_short ? GATE_TRUNC : GATE_DROP;
                    end
                end
            end
            GATE_DROP: begin
                if (!lv) trk_d.mode = GATE_PASS;
            end
            GATE_TRUNC: begin
                pass = lv && met;
                if (!lv) trk_d.mode = GATE_PASS;
            end
            default: begin
                pass = lv;
            end
        endcase

        if (!fv) begin
            trk_d.mode = GATE_WAIT;
            pass       = 1'b0;
            err        = 1'b0;
        end
        trk_d.lv_prev = fv && lv;

        out_d.fv   = fv;
        out_d.lv   = pass;
        out_d.data = pass ? data : '0;
        out_d.err  = err;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q <= '{mode: GATE_WAIT, lv_prev: 1'b0};
            out_q <= '0;
        end else begin
            trk_q <= trk_d;
            out_q <= out_d;
        end
    end

    always_comb begin
        o_fv   = out_q.fv;
        o_lv   = out_q.lv;
        o_data = out_q.data;
        o_err  = out_q.err;
    end
endmodule

// File: rtl/fv_line_gate.sv
module fv_line_gate #(
    parameter int DATA_W = 12,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_fv_inv,
    input  logic              cfg_lv_inv,
    input  logic              cfg_fwd_short,
    input  logic [CNT_W-1:0]  cfg_min_setup,
    input  logic              in_fv,
    input  logic              in_lv,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_fv,
    output logic              out_lv,
    output logic [DATA_W-1:0] out_data,
    output logic              out_err
);
    logic             fv_norm;
    logic             lv_norm;
    logic             setup_met;
    logic [CNT_W-1:0] cnt_val;

    fvlg_polarity u_pol (
        .inv_fv  (cfg_fv_inv),
        .inv_lv  (cfg_lv_inv),
        .raw_fv  (in_fv),
        .raw_lv  (in_lv),
        .norm_fv (fv_norm),
        .norm_lv (lv_norm)
    );

    fvlg_setup_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .fv        (fv_norm),
        .min_setup (cfg_min_setup),
        .cnt_o     (cnt_val),
        .met_o     (setup_met)
    );

    fvlg_line_gate #(.DATA_W(DATA_W)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .fv        (fv_norm),
        .lv        (lv_norm),
        .data      (in_data),
        .met       (setup_met),
        .fwd_short (cfg_fwd_short),
        .o_fv      (out_fv),
        .o_lv      (out_lv),
        .o_data    (out_data),
        .o_err     (out_err)
    );
endmodule

// File: rtl/fvlg_checker.sv
module fvlg_checker #(
    parameter int DATA_W = 12,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_fv_inv,
    input logic              in_fv,
    input logic              fv_n,
    input logic [CNT_W-1:0]  cnt,
    input logic              out_fv,
    input logic              out_lv,
    input logic [DATA_W-1:0] out_data,
    input logic              out_err
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    a_r11_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_fv && !out_lv && !out_err && out_data == '0));

    a_r3_fv_one_stage: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (out_fv == $past(in_fv ^ cfg_fv_inv)));

    a_r10_data_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !out_lv |-> (out_data == '0));

    a_r7_err_single: assert property (@(posedge clk) disable iff (rst)
        out_err |=> !out_err);

    a_r8_lv_inside_fv: assert property (@(posedge clk) disable iff (rst)
        out_lv |-> out_fv);

    a_r9_count_clear: assert property (@(posedge clk) disable iff (rst)
        !fv_n |=> (cnt == '0));

    a_r12_count_holds_max: assert property (@(posedge clk) disable iff (rst)
        (fv_n && cnt == CMAX) |=> (cnt == CMAX));
endmodule

bind fv_line_gate fvlg_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_fv_inv (cfg_fv_inv),
    .in_fv      (in_fv),
    .fv_n       (fv_norm),
    .cnt        (cnt_val),
    .out_fv     (out_fv),
    .out_lv     (out_lv),
    .out_data   (out_data),
    .out_err    (out_err)
);

// File: tb/fv_line_gate_bench.sv
`timescale 1ns/1ps
module fv_line_gate_bench;
    localparam int DW = 12;
    localparam int CW = 16;
    localparam int LLEN = 4;
    localparam int LGAP = 2;
    localparam int NLINES = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_fv_inv, cfg_lv_inv, cfg_fwd_short;
    logic [CW-1:0] cfg_min_setup;
    logic          in_fv, in_lv;
    logic [DW-1:0] in_data;
    logic          out_fv, out_lv, out_err;
    logic [DW-1:0] out_data;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    fv_line_gate u_fv_line_gate (
        .clk(clk), .rst(rst),
        .cfg_fv_inv(cfg_fv_inv), .cfg_lv_inv(cfg_lv_inv),
        .cfg_fwd_short(cfg_fwd_short), .cfg_min_setup(cfg_min_setup),
        .in_fv(in_fv), .in_lv(in_lv), .in_data(in_data),
        .out_fv(out_fv), .out_lv(out_lv), .out_data(out_data), .out_err(out_err)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // drive normalised strobes through the configured polarity, then check one stage later
    task automatic step(input bit fvn, input bit lvn, input logic [DW-1:0] d,
                        input bit exp_lv, input bit exp_err, input string tag_lv);
        in_fv   = fvn ^ cfg_fv_inv;
        in_lv   = lvn ^ cfg_lv_inv;
        in_data = d;
        @(negedge clk);
        check(32'(out_fv), 32'(fvn), "R3 R1 out_fv");
        check(32'(out_lv), 32'(exp_lv), tag_lv);
        check(32'(out_data), exp_lv ? 32'(d) : 32'd0, "R10 out_data");
        check(32'(out_err), 32'(exp_err), "R7 out_err");
    endtask

    task automatic run_frame(input int k, input int mn, input bit fwd);
        int span = k + NLINES * (LLEN + LGAP);
        for (int t = 0; t < span; t++) begin
            int  rel  = t - k;
            int  j    = (rel >= 0) ? rel / (LLEN + LGAP) : -1;
            bit  inl  = (rel >= 0) && ((rel % (LLEN + LGAP)) < LLEN);
            bit  elv  = 1'b0;
            bit  eer  = inl && (t == k) && (k < mn);
            string tg = "R8 later line";
            if (inl && j == 0) begin
                if (k >= mn) begin
                    elv = 1'b1; tg = "R4 R9 first line ok";
                end else if (fwd) begin
                    elv = (t >= mn); tg = "R6 first line truncated";
                end else begin
                    elv = 1'b0; tg = "R5 first line dropped";
                end
            end else if (inl) begin
                elv = 1'b1;
            end
            step(1'b1, inl, DW'(t * 5 + k + 1), elv, eer, tg);
        end
        for (int g = 0; g < 3; g++)
            step(1'b0, 1'b0, DW'(g + 7), 1'b0, 1'b0, "R3 gap lv low");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cfg_fv_inv = 1'b0; cfg_lv_inv = 1'b0; cfg_fwd_short = 1'b0;
        cfg_min_setup = '0;
        in_fv = 1'b1; in_lv = 1'b1; in_data = '1;
        repeat (3) @(negedge clk);
        // R11: busy inputs during reset, outputs must still be idle
        check(32'(out_fv), 0, "R11 reset out_fv");
        check(32'(out_lv), 0, "R11 reset out_lv");
        check(32'(out_data), 0, "R11 reset out_data");
        check(32'(out_err), 0, "R11 reset out_err");
        in_fv = 1'b0; in_lv = 1'b0;
        @(negedge clk);
        rst = 1'b0;

        for (int pol = 0; pol < 4; pol++) begin
            for (int fm = 0; fm < 2; fm++) begin
                for (int mi = 0; mi < 4; mi++) begin
                    for (int k = 0; k < 8; k++) begin
                        int mn = (mi == 0) ? 0 : (mi == 1) ? 1 : (mi == 2) ? 3 : 5;
                        cfg_fv_inv    = pol[0];
                        cfg_lv_inv    = pol[1];
                        cfg_fwd_short = fm[0];
                        cfg_min_setup = CW'(mn);
                        step(1'b0, 1'b0, '0, 1'b0, 1'b0, "R2 idle");
                        run_frame(k, mn, fm[0]);
                    end
                end
            end
        end

        // R12: long frame lead with maximum setup, count must hold at its ceiling
        cfg_fv_inv = 1'b0; cfg_lv_inv = 1'b0; cfg_fwd_short = 1'b0;
        cfg_min_setup = 16'hFFFF;
        in_fv = 1'b1; in_lv = 1'b0;
        repeat (65540) @(negedge clk);
        for (int t = 0; t < LLEN; t++)
            step(1'b1, 1'b1, DW'(t + 3), 1'b1, 1'b0, "R12 saturated count line");
        step(1'b0, 1'b0, '0, 1'b0, 1'b0, "R12 end");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule